// File: doc/BRIEF.md
# Actor Event Dispatch Queue

This block holds the message-events waiting for delivery to actors. Each pending event is a four-word cell in a small on-chip cell store: the sponsor word, the target actor reference, the message word, and a link to the next cell. The waiting cells form a singly linked list that starts at a head register and ends at a tail register. Address zero is the null link. It marks the end of the list and, when held in the head register, an empty queue. Because each cell carries its own link, the queue grows without a length limit up to the size of the store.

The block examines the head cell on every clock. If the target actor is idle, it marks the actor busy, unlinks the cell and issues a one-cycle dispatch pulse carrying the cell's contents. If the actor is busy, the cell is moved to the tail, so events for other actors are not held up. When the busy cell is the only one in the queue, it stays in place and is tried again on the next cycle.

Producers (a committing transaction, or an I/O source) first write their cells through the cell write port. They then hand the whole chain over in one cycle by giving its first and last addresses on the enqueue port. An aborted transaction never enqueues its cells. Either outcome frees the actor through the release port.

Top module: `evq_dispatch`

## Requirements
- R1: When the head cell's target is idle, `disp_valid` is high for exactly the cycle after that clock, with `disp_event` equal to the cell address and `disp_sponsor`, `disp_target` and `disp_msg` equal to the values written to that cell.
- R2: A dispatch marks its target actor busy. No later event for that actor is dispatched until a release names that actor.
- R3: When the head cell's target is busy and the queue holds more than one cell, the head cell is relinked behind the tail. The cells that followed it are examined first, and the queue order is otherwise kept.
- R4: When the queue holds a single cell whose target is busy, head and tail stay unchanged and the cell is retried every cycle. A release takes effect in the cycle it is presented, so the cell is dispatched on that same clock.
- R5: An enqueue of first address F and last address L (the last cell's link written as 0) makes F..L the queue if the queue is empty. Otherwise it links F behind the current tail. In both cases the tail becomes L. Address 0 is the null link, and the head and tail registers are null together.
- R6: An enqueue presented in the cycle that dispatches the last queued cell is not lost, and its chain is dispatched afterwards.
- R7: Cells written but never enqueued, as after an abort, are never dispatched. A release of an actor that is already idle causes no dispatch.
- R8: While reset is asserted and after it is released, the queue is empty, every actor is idle and `disp_valid` is low. A cell held in the queue before reset is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write a whole cell this cycle |
| wr_addr | input | ADDR_W | Cell address to write |
| wr_sponsor | input | WORD_W | Sponsor word |
| wr_target | input | ADDR_W | Target actor reference |
| wr_msg | input | WORD_W | Message word |
| wr_next | input | ADDR_W | Link to next cell (0 = end) |
| enq_valid | input | 1 | Splice a chain onto the queue |
| enq_first | input | ADDR_W | First cell of the chain |
| enq_last | input | ADDR_W | Last cell of the chain |
| rel_valid | input | 1 | Return an actor to idle |
| rel_actor | input | ADDR_W | Actor to release |
| disp_valid | output | 1 | Dispatch pulse |
| disp_event | output | ADDR_W | Address of dispatched cell |
| disp_sponsor | output | WORD_W | Sponsor of dispatched event |
| disp_target | output | ADDR_W | Target actor of dispatched event |
| disp_msg | output | WORD_W | Message of dispatched event |

## Verification
The bench drives the rotation path with a busy cell ahead of idle ones, and checks that the dispatch order is the idle cells first and the recycled one last. A design that dropped the link rewrite would lose or repeat cells. It parks a lone busy cell and then splices a new chain behind it. A tail pointer that is not updated would strand the new chain. It also lines up an enqueue with the clock that empties the queue, which a design would lose if it decided emptiness from the old head. It checks that a release and the retry in the same cycle dispatch at once, that an aborted chain stays silent, and that reset clears both the queue and the busy set.

// File: rtl/evq_pkg.sv
package evq_pkg;

  // What the head controller does with the head cell in a given cycle.
  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,  // queue empty
    ACT_DISPATCH = 2'd1,  // target idle: unlink and deliver
    ACT_ROTATE   = 2'd2,  // target busy, other cells waiting: move to tail
    ACT_HOLD     = 2'd3   // target busy, lone cell: leave in place
  } head_act_e;

  localparam int N_LINK_PORTS = 3;

endpackage

// File: rtl/evq_cell_store.sv
module evq_cell_store
  import evq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [WORD_W-1:0]                     wr_sponsor,
  input  logic [ADDR_W-1:0]                     wr_target,
  input  logic [WORD_W-1:0]                     wr_msg,
  input  logic [ADDR_W-1:0]                     wr_next,
  input  logic [N_LINK_PORTS-1:0]               lnk_en,
  input  logic [N_LINK_PORTS-1:0][ADDR_W-1:0]   lnk_addr,
  input  logic [N_LINK_PORTS-1:0][ADDR_W-1:0]   lnk_val,
  input  logic [ADDR_W-1:0]                     rd_addr,
  output logic [WORD_W-1:0]                     rd_sponsor,
  output logic [ADDR_W-1:0]                     rd_target,
  output logic [WORD_W-1:0]                     rd_msg,
  output logic [ADDR_W-1:0]                     rd_next
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] spon_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q  [DEPTH];
  logic [WORD_W-1:0] msg_q  [DEPTH];
  logic [ADDR_W-1:0] next_q [DEPTH];

  // Link-only writes come after the full cell write; a higher port index wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        spon_q[i] <= '0;
        tgt_q[i]  <= '0;
        msg_q[i]  <= '0;
        next_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && (wr_addr == ADDR_W'(i))) begin
          spon_q[i] <= wr_sponsor;
          tgt_q[i]  <= wr_target;
          msg_q[i]  <= wr_msg;
          next_q[i] <= wr_next;
        end
        for (int k = 0; k < N_LINK_PORTS; k++) begin
          if (lnk_en[k] && (lnk_addr[k] == ADDR_W'(i))) begin
            next_q[i] <= lnk_val[k];
          end
        end
      end
    end
  end

  assign rd_sponsor = spon_q[rd_addr];
  assign rd_target  = tgt_q[rd_addr];
  assign rd_msg     = msg_q[rd_addr];
  assign rd_next    = next_q[rd_addr];

endmodule

// File: rtl/evq_busy_table.sv
module evq_busy_table #(
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     chk_actor,
  output logic                  chk_busy,
  input  logic                  set_en,
  input  logic [ADDR_W-1:0]     set_actor,
  input  logic                  rel_en,
  input  logic [ADDR_W-1:0]     rel_actor,
  output logic [(1<<ADDR_W)-1:0] busy_vec
);

  localparam int SLOTS = 1 << ADDR_W;

  logic [SLOTS-1:0] busy_q;

  // A release presented this cycle already counts for the lookup.
  function automatic logic lookup(input logic [SLOTS-1:0] bits,
                                  input logic [ADDR_W-1:0] who,
                                  input logic rel, input logic [ADDR_W-1:0] rel_who);
    return bits[who] && !(rel && (rel_who == who));
  endfunction

  assign chk_busy = lookup(busy_q, chk_actor, rel_en, rel_actor);
  assign busy_vec = busy_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[s] <= 1'b0;
      end else if (set_en && (set_actor == ADDR_W'(s))) begin
        busy_q[s] <= 1'b1;
      end else if (rel_en && (rel_actor == ADDR_W'(s))) begin
        busy_q[s] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/evq_head_ctrl.sv
module evq_head_ctrl
  import evq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   cell_next,
  input  logic                                tgt_busy,
  input  logic                                enq_en,
  input  logic [ADDR_W-1:0]                   enq_first,
  input  logic [ADDR_W-1:0]                   enq_last,
  output logic [ADDR_W-1:0]                   head_q,
  output logic [ADDR_W-1:0]                   tail_q,
  output head_act_e                           act,
  output logic [N_LINK_PORTS-1:0]             lnk_en,
  output logic [N_LINK_PORTS-1:0][ADDR_W-1:0] lnk_addr,
  output logic [N_LINK_PORTS-1:0][ADDR_W-1:0] lnk_val
);

  localparam logic [ADDR_W-1:0] NULL_LINK = '0;

  function automatic head_act_e classify(input logic [ADDR_W-1:0] h,
                                         input logic [ADDR_W-1:0] t,
                                         input logic busy);
    if (h == NULL_LINK) return ACT_NONE;
    if (!busy)          return ACT_DISPATCH;
    if (h == t)         return ACT_HOLD;
    return ACT_ROTATE;
  endfunction

  function automatic logic [ADDR_W-1:0] head_after(input head_act_e a,
                                                   input logic [ADDR_W-1:0] h,
                                                   input logic [ADDR_W-1:0] nxt);
    return (a == ACT_DISPATCH || a == ACT_ROTATE) ? nxt : h;
  endfunction

  function automatic logic [ADDR_W-1:0] tail_after(input head_act_e a,
                                                   input logic [ADDR_W-1:0] h,
                                                   input logic [ADDR_W-1:0] t,
                                                   input logic [ADDR_W-1:0] nxt);
    case (a)
      ACT_DISPATCH: return (nxt == NULL_LINK) ? NULL_LINK : t;
      ACT_ROTATE:   return h;
      default:      return t;
    endcase
  endfunction

  logic [ADDR_W-1:0] head_mid, tail_mid, head_d, tail_d;

  assign act      = classify(head_q, tail_q, tgt_busy);
  assign head_mid = head_after(act, head_q, cell_next);
  assign tail_mid = tail_after(act, head_q, tail_q, cell_next);

  // Splice applies on top of the head step.
  assign head_d = (enq_en && (head_mid == NULL_LINK)) ? enq_first : head_mid;
  assign tail_d = enq_en ? enq_last : tail_mid;

  always_comb begin
    lnk_en   = '0;
    lnk_addr = '0;
    lnk_val  = '0;
    // Port 0: old tail now points at the recycled head.
    lnk_en[0]   = (act == ACT_ROTATE);
    lnk_addr[0] = tail_q;
    lnk_val[0]  = head_q;
    // Port 1: recycled cell becomes the end of the list.
    lnk_en[1]   = (act == ACT_ROTATE);
    lnk_addr[1] = head_q;
    lnk_val[1]  = NULL_LINK;
    // Port 2: splice, overriding port 1 when it lands on the same cell.
    lnk_en[2]   = enq_en && (tail_mid != NULL_LINK);
    lnk_addr[2] = tail_mid;
    lnk_val[2]  = enq_first;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= NULL_LINK;
      tail_q <= NULL_LINK;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

endmodule

// File: rtl/evq_dispatch.sv
module evq_dispatch
  import evq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_sponsor,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [WORD_W-1:0] wr_msg,
  input  logic [ADDR_W-1:0] wr_next,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_first,
  input  logic [ADDR_W-1:0] enq_last,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_actor,
  output logic              disp_valid,
  output logic [ADDR_W-1:0] disp_event,
  output logic [WORD_W-1:0] disp_sponsor,
  output logic [ADDR_W-1:0] disp_target,
  output logic [WORD_W-1:0] disp_msg
);

  localparam int SLOTS = 1 << ADDR_W;

  // Named internal events, used by the bound checker.
  logic [ADDR_W-1:0] head_q, tail_q;
  logic [WORD_W-1:0] cell_sponsor, cell_msg;
  logic [ADDR_W-1:0] cell_target, cell_next;
  logic              head_busy;
  head_act_e         act;
  logic              do_dispatch, do_rotate, do_hold;
  logic [SLOTS-1:0]  busy_vec;

  logic [N_LINK_PORTS-1:0]             lnk_en;
  logic [N_LINK_PORTS-1:0][ADDR_W-1:0] lnk_addr;
  logic [N_LINK_PORTS-1:0][ADDR_W-1:0] lnk_val;

  evq_cell_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_sponsor (wr_sponsor),
    .wr_target  (wr_target),
    .wr_msg     (wr_msg),
    .wr_next    (wr_next),
    .lnk_en     (lnk_en),
    .lnk_addr   (lnk_addr),
    .lnk_val    (lnk_val),
    .rd_addr    (head_q),
    .rd_sponsor (cell_sponsor),
    .rd_target  (cell_target),
    .rd_msg     (cell_msg),
    .rd_next    (cell_next)
  );

  evq_busy_table #(.ADDR_W(ADDR_W)) u_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_actor (cell_target),
    .chk_busy  (head_busy),
    .set_en    (do_dispatch),
    .set_actor (cell_target),
    .rel_en    (rel_valid),
    .rel_actor (rel_actor),
    .busy_vec  (busy_vec)
  );

  evq_head_ctrl #(.ADDR_W(ADDR_W)) u_head (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_next (cell_next),
    .tgt_busy  (head_busy),
    .enq_en    (enq_valid),
    .enq_first (enq_first),
    .enq_last  (enq_last),
    .head_q    (head_q),
    .tail_q    (tail_q),
    .act       (act),
    .lnk_en    (lnk_en),
    .lnk_addr  (lnk_addr),
    .lnk_val   (lnk_val)
  );

  assign do_dispatch = (act == ACT_DISPATCH);
  assign do_rotate   = (act == ACT_ROTATE);
  assign do_hold     = (act == ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid   <= 1'b0;
      disp_event   <= '0;
      disp_sponsor <= '0;
      disp_target  <= '0;
      disp_msg     <= '0;
    end else begin
      disp_valid <= do_dispatch;
      if (do_dispatch) begin
        disp_event   <= head_q;
        disp_sponsor <= cell_sponsor;
        disp_target  <= cell_target;
        disp_msg     <= cell_msg;
      end
    end
  end

endmodule

// File: rtl/evq_dispatch_checker.sv
module evq_dispatch_checker #(
  parameter int ADDR_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enq_valid,
  input logic [ADDR_W-1:0]      enq_last,
  input logic                   disp_valid,
  input logic [ADDR_W-1:0]      disp_event,
  input logic [ADDR_W-1:0]      disp_target,
  input logic [ADDR_W-1:0]      head_q,
  input logic [ADDR_W-1:0]      tail_q,
  input logic [ADDR_W-1:0]      cell_next,
  input logic [ADDR_W-1:0]      cell_target,
  input logic                   do_dispatch,
  input logic                   do_rotate,
  input logic                   do_hold,
  input logic [(1<<ADDR_W)-1:0] busy_vec
);

  assert_empty_no_dispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q == '0) |=> !disp_valid);

  assert_dispatch_payload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_event == $past(head_q)) && (disp_target == $past(cell_target)));

  assert_dispatch_marks_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_dispatch |=> busy_vec[$past(cell_target)]);

  assert_rotate_to_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rotate && !enq_valid) |=> (tail_q == $past(head_q)) && (head_q == $past(cell_next)));

  assert_lone_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_hold && !enq_valid) |=> $stable(head_q) && $stable(tail_q));

  assert_splice_sets_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |=> (tail_q == $past(enq_last)));

  assert_null_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q == '0) == (tail_q == '0));

endmodule

bind evq_dispatch evq_dispatch_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enq_valid   (enq_valid),
  .enq_last    (enq_last),
  .disp_valid  (disp_valid),
  .disp_event  (disp_event),
  .disp_target (disp_target),
  .head_q      (head_q),
  .tail_q      (tail_q),
  .cell_next   (cell_next),
  .cell_target (cell_target),
  .do_dispatch (do_dispatch),
  .do_rotate   (do_rotate),
  .do_hold     (do_hold),
  .busy_vec    (busy_vec)
);

// File: tb/evq_dispatch_bench.sv
`timescale 1ns/1ps
module evq_dispatch_bench;

  localparam int ADDR_W = 6;
  localparam int WORD_W = 16;

  // Row: op[31:28] a[27:20] b[19:12] c[11:4] req[3:0]
  localparam logic [3:0] OP_WR = 4'd1, OP_ENQ = 4'd2, OP_REL = 4'd3,
                         OP_IDLE = 4'd4, OP_CHK = 4'd5, OP_CNT = 4'd6;
  localparam int N_ROWS = 54;
  localparam logic [31:0] PROG [N_ROWS] = '{
    {OP_WR,  8'd1,  8'd40, 8'd2,  4'd1},   // R1 cell 1 -> actor 40
    {OP_WR,  8'd2,  8'd41, 8'd3,  4'd1},
    {OP_WR,  8'd3,  8'd40, 8'd0,  4'd1},
    {OP_ENQ, 8'd1,  8'd3,  8'd0,  4'd5},   // R5 splice onto empty queue
    {OP_IDLE,8'd6,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd2,  8'd0,  8'd0,  4'd2},   // R2 cell 3 waits on busy 40
    {OP_CHK, 8'd0,  8'd1,  8'd0,  4'd1},   // R1
    {OP_CHK, 8'd1,  8'd2,  8'd0,  4'd1},   // R1
    {OP_REL, 8'd40, 8'd0,  8'd0,  4'd4},   // R4 release meets lone retry
    {OP_IDLE,8'd3,  8'd0,  8'd0,  4'd0},
    {OP_CHK, 8'd2,  8'd3,  8'd0,  4'd4},   // R4
    {OP_CNT, 8'd3,  8'd0,  8'd0,  4'd4},   // R4
    {OP_WR,  8'd4,  8'd41, 8'd5,  4'd3},   // R3 busy head ahead of idle cells
    {OP_WR,  8'd5,  8'd42, 8'd6,  4'd3},
    {OP_WR,  8'd6,  8'd43, 8'd0,  4'd3},
    {OP_ENQ, 8'd4,  8'd6,  8'd0,  4'd3},
    {OP_IDLE,8'd6,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd5,  8'd0,  8'd0,  4'd3},   // R3
    {OP_CHK, 8'd3,  8'd5,  8'd0,  4'd3},   // R3
    {OP_CHK, 8'd4,  8'd6,  8'd0,  4'd3},   // R3
    {OP_WR,  8'd7,  8'd44, 8'd8,  4'd5},   // R5 splice behind held cell 4
    {OP_WR,  8'd8,  8'd45, 8'd0,  4'd5},
    {OP_ENQ, 8'd7,  8'd8,  8'd0,  4'd5},
    {OP_IDLE,8'd6,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd7,  8'd0,  8'd0,  4'd5},   // R5
    {OP_CHK, 8'd5,  8'd7,  8'd0,  4'd5},   // R5
    {OP_CHK, 8'd6,  8'd8,  8'd0,  4'd5},   // R5
    {OP_REL, 8'd41, 8'd0,  8'd0,  4'd4},
    {OP_IDLE,8'd3,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd8,  8'd0,  8'd0,  4'd4},   // R4
    {OP_CHK, 8'd7,  8'd4,  8'd0,  4'd3},   // R3 recycled cell comes last
    {OP_WR,  8'd9,  8'd46, 8'd0,  4'd7},   // R7 written, never enqueued
    {OP_REL, 8'd42, 8'd0,  8'd0,  4'd7},
    {OP_REL, 8'd47, 8'd0,  8'd0,  4'd7},   // R7 release of idle actor
    {OP_IDLE,8'd4,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd8,  8'd0,  8'd0,  4'd7},   // R7
    {OP_WR,  8'd10, 8'd48, 8'd11, 4'd2},   // R2 two events for one actor
    {OP_WR,  8'd11, 8'd48, 8'd0,  4'd2},
    {OP_ENQ, 8'd10, 8'd11, 8'd0,  4'd2},
    {OP_IDLE,8'd4,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd9,  8'd0,  8'd0,  4'd2},   // R2
    {OP_CHK, 8'd8,  8'd10, 8'd0,  4'd2},   // R2
    {OP_REL, 8'd48, 8'd0,  8'd0,  4'd4},
    {OP_IDLE,8'd3,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd10, 8'd0,  8'd0,  4'd4},   // R4
    {OP_CHK, 8'd9,  8'd11, 8'd0,  4'd4},   // R4
    {OP_WR,  8'd13, 8'd50, 8'd0,  4'd6},   // R6 enqueue on emptying clock
    {OP_WR,  8'd14, 8'd51, 8'd0,  4'd6},
    {OP_ENQ, 8'd13, 8'd13, 8'd0,  4'd6},
    {OP_ENQ, 8'd14, 8'd14, 8'd0,  4'd6},
    {OP_IDLE,8'd4,  8'd0,  8'd0,  4'd0},
    {OP_CNT, 8'd12, 8'd0,  8'd0,  4'd6},   // R6
    {OP_CHK, 8'd10, 8'd13, 8'd0,  4'd6},   // R6
    {OP_CHK, 8'd11, 8'd14, 8'd0,  4'd6}    // R6
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_sponsor = '0;
  logic [ADDR_W-1:0] wr_target = '0;
  logic [WORD_W-1:0] wr_msg = '0;
  logic [ADDR_W-1:0] wr_next = '0;
  logic              enq_valid = 1'b0;
  logic [ADDR_W-1:0] enq_first = '0;
  logic [ADDR_W-1:0] enq_last = '0;
  logic              rel_valid = 1'b0;
  logic [ADDR_W-1:0] rel_actor = '0;
  logic              disp_valid;
  logic [ADDR_W-1:0] disp_event;
  logic [WORD_W-1:0] disp_sponsor;
  logic [ADDR_W-1:0] disp_target;
  logic [WORD_W-1:0] disp_msg;

  evq_dispatch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_evq_dispatch (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sponsor(wr_sponsor),
    .wr_target(wr_target), .wr_msg(wr_msg), .wr_next(wr_next),
    .enq_valid(enq_valid), .enq_first(enq_first), .enq_last(enq_last),
    .rel_valid(rel_valid), .rel_actor(rel_actor),
    .disp_valid(disp_valid), .disp_event(disp_event), .disp_sponsor(disp_sponsor),
    .disp_target(disp_target), .disp_msg(disp_msg)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Dispatch log, filled at falling edges.
  int                log_cnt = 0;
  logic [ADDR_W-1:0] log_ev  [32];
  logic [ADDR_W-1:0] log_tgt [32];
  logic [WORD_W-1:0] log_msg [32];
  logic [WORD_W-1:0] log_spn [32];
  logic [ADDR_W-1:0] shadow_tgt [1<<ADDR_W];

  function automatic logic [WORD_W-1:0] msg_of(input int a);
    return WORD_W'(a * 7 + 1);
  endfunction
  function automatic logic [WORD_W-1:0] spon_of(input int a);
    return WORD_W'(a) ^ 16'h5A00;
  endfunction

  always @(negedge clk) begin
    if (rst_n && disp_valid && log_cnt < 32) begin
      log_ev[log_cnt]  = disp_event;
      log_tgt[log_cnt] = disp_target;
      log_msg[log_cnt] = disp_msg;
      log_spn[log_cnt] = disp_sponsor;
      log_cnt++;
    end
  end

  task automatic check(input int req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    wr_en = 1'b0; enq_valid = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] row);
    logic [3:0] op;
    int a, b, r;
    op = row[31:28]; a = int'(row[27:20]); b = int'(row[19:12]); r = int'(row[3:0]);
    case (op)
      OP_WR: begin
        @(negedge clk);
        clear_inputs();
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_target = ADDR_W'(b);
        wr_next = ADDR_W'(row[11:4]); wr_msg = msg_of(a); wr_sponsor = spon_of(a);
        shadow_tgt[a] = ADDR_W'(b);
      end
      OP_ENQ: begin
        @(negedge clk);
        clear_inputs();
        enq_valid = 1'b1; enq_first = ADDR_W'(a); enq_last = ADDR_W'(b);
      end
      OP_REL: begin
        @(negedge clk);
        clear_inputs();
        rel_valid = 1'b1; rel_actor = ADDR_W'(a);
      end
      OP_IDLE: begin
        for (int k = 0; k < a; k++) begin
          @(negedge clk);
          clear_inputs();
        end
      end
      OP_CNT: begin
        #1;
        check(r, "dispatch count", log_cnt, a);
      end
      OP_CHK: begin
        #1;
        if (a >= log_cnt) begin
          check(r, "missing dispatch entry", log_cnt, a + 1);
        end else begin
          check(r, "dispatched event", int'(log_ev[a]), b);
          check(r, "dispatched target", int'(log_tgt[a]), int'(shadow_tgt[b]));
          check(r, "dispatched message", int'(log_msg[a]), int'(msg_of(b)));
          check(r, "dispatched sponsor", int'(log_spn[a]), int'(spon_of(b)));
        end
      end
      default: ;
    endcase
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    check(8, "disp_valid in reset", int'(disp_valid), 0);   // R8
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(8, "disp_valid after reset", int'(disp_valid), 0); // R8

    for (int i = 0; i < N_ROWS; i++) run_op(PROG[i]);

    // R8: a lone cell waiting on busy actor 51 is cleared by reset,
    // and reset also clears the busy set.
    run_op({OP_WR,  8'd15, 8'd51, 8'd0, 4'd8});
    run_op({OP_ENQ, 8'd15, 8'd15, 8'd0, 4'd8});
    run_op({OP_IDLE,8'd3,  8'd0,  8'd0, 4'd8});
    base = log_cnt;
    check(8, "held cell not dispatched before reset", log_cnt, 12);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(8, "disp_valid during mid-run reset", int'(disp_valid), 0);
    rst_n = 1'b1;
    run_op({OP_IDLE,8'd4,  8'd0,  8'd0, 4'd8});
    check(8, "queue emptied by reset", log_cnt, base);
    run_op({OP_WR,  8'd16, 8'd51, 8'd0, 4'd8});
    run_op({OP_ENQ, 8'd16, 8'd16, 8'd0, 4'd8});
    run_op({OP_IDLE,8'd3,  8'd0,  8'd0, 4'd8});
    run_op({OP_CNT, 8'd13, 8'd0,  8'd0, 4'd8});
    run_op({OP_CHK, 8'd12, 8'd16, 8'd0, 4'd8});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule